// File: doc/BRIEF.md
# Gated Timestamp Capture Bank

This block is a bank of independent event-capture channels that share a free-running time counter supplied on an input bus, typically a network-disciplined 64-bit time value. Every external input line first passes through a multi-flop synchroniser and an edge detector. Each channel picks one synchronised input as its trigger source and listens for a chosen edge direction. It may also qualify the trigger with the level of a second input, which then acts as a gate. When the trigger fires, the channel stores the current time together with a status word. The status word holds the synchronised level of every input and marks which inputs changed in that same cycle.

Each channel queues its records in a small private FIFO. Software selects a channel on a register-style read port, sees the oldest record with a valid flag, and removes it with a pop strobe. The time value and the status word come from the same FIFO entry, so they always describe the same event. A full FIFO drops new captures and raises a sticky per-channel overflow flag, which software clears. A single interrupt line is asserted while any interrupt-enabled channel holds data, and the lowest-numbered such channel is reported with it.

Top module: `ts_capture_bank`

## Requirements
- R1: After reset every channel FIFO is empty, `rd_valid` is 0, `irq` is 0 and `ovf_flags` is all zero.
- R2: With the default two synchroniser stages, suppose an input change is applied before clock edge k. The record then holds the `time_now` value present in the cycle just before edge k+2, and `rd_valid` shows it after edge k+2.
- R3: Each channel's two-bit edge select `cfg_edge[2c+1:2c]` works as follows: bit 0 enables rising-edge captures, bit 1 enables falling-edge captures, 2'b11 captures on both edges, and 2'b00 captures nothing.
- R4: If `cfg_gate_en[c]` is 1, a channel captures only while the synchronised level of its gate input (`cfg_gate_sel`) equals `cfg_gate_pol[c]`. If `cfg_gate_en[c]` is 0, the gate input has no effect.
- R5: A channel with `cfg_enable[c]` at 0 stores no record, whatever happens on its inputs.
- R6: The status word `rd_status` holds the synchronised levels of all inputs in bits [NUM_IN-1:0], as they were in the capture cycle. Bits [2*NUM_IN-1:NUM_IN] are 1 for each input that changed in that same cycle, and the input's level gives the direction of that change.
- R7: Records come out of a channel in capture order. A pop while `rd_valid` is 1 removes the head of the channel chosen by `rd_ch`. A pop while `rd_valid` is 0 has no effect on any channel.
- R8: A capture that arrives at a full FIFO is dropped and leaves the stored records unchanged. It also sets that channel's bit in `ovf_flags`, and the bit stays set until a cycle with `ovf_clr[c]` high and no new drop.
- R9: `irq` is 1 exactly when some channel is non-empty and has `irq_en[c]` set. `irq_ch` then names the lowest-numbered such channel.
- R10: While `rd_valid` is 1 and neither a pop happens nor `rd_ch` changes, `rd_time` and `rd_status` stay unchanged, even when new captures enter the same FIFO.
- R11: Channels with the same source and edge setting capture the same event with identical timestamps, and they do so independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | TIME_W | Free-running time counter value |
| ext_in | input | NUM_IN | Asynchronous external event inputs |
| cfg_enable | input | NUM_CH | Per-channel capture enable |
| cfg_edge | input | 2*NUM_CH | Per-channel edge select, bit 0 rising, bit 1 falling |
| cfg_trig_sel | input | NUM_CH*SEL_W | Per-channel trigger input index |
| cfg_gate_sel | input | NUM_CH*SEL_W | Per-channel gate input index |
| cfg_gate_en | input | NUM_CH | Per-channel gate enable |
| cfg_gate_pol | input | NUM_CH | Gate level that opens the gate |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| ovf_clr | input | NUM_CH | Per-channel overflow clear strobe |
| rd_ch | input | CH_W | Channel selected on the read port |
| rd_pop | input | 1 | Remove the head record of the selected channel |
| rd_valid | output | 1 | Selected channel holds a record |
| rd_time | output | TIME_W | Timestamp of the head record |
| rd_status | output | 2*NUM_IN | Status word of the head record |
| ovf_flags | output | NUM_CH | Sticky overflow flags |
| irq | output | 1 | Any enabled channel pending |
| irq_ch | output | CH_W | Lowest pending enabled channel |

## Verification
The bench builds the block with four channels, four inputs, a 64-bit time bus and a FIFO depth of two. The shallow FIFO makes overflow happen after only two queued events, so record ordering, dropping and the sticky flag all fit into a few cycles. With four channels, priority between the pending channels and masking by the interrupt enable can be tried against several sources driven by one shared input. The time counter starts just below a 32-bit carry, so the checks on stored timestamps also cover the upper word.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  localparam int EDGE_RISE_BIT = 0;
  localparam int EDGE_FALL_BIT = 1;

  // True when the selected edge mode matches the observed edge.
  function automatic logic edge_hit(input logic [1:0] mode, input logic rise, input logic fall);
    return (mode[EDGE_RISE_BIT] & rise) | (mode[EDGE_FALL_BIT] & fall);
  endfunction

  // Gate is open when unused, or when the gate level matches the polarity.
  function automatic logic gate_open(input logic use_gate, input logic pol, input logic level);
    return ~use_gate | (level == pol);
  endfunction

endpackage

// File: rtl/ts_cap_sync.sv
module ts_cap_sync #(
  parameter int N_IN   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] async_in,
  output logic [N_IN-1:0] level,
  output logic [N_IN-1:0] rise,
  output logic [N_IN-1:0] fall
);

  logic [N_IN-1:0] chain [STAGES];
  logic [N_IN-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      last <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;

endmodule

// File: rtl/ts_cap_fifo.sv
module ts_cap_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp;
  logic [AW:0]  rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

endmodule

// File: rtl/ts_cap_channel.sv
module ts_cap_channel
  import ts_cap_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int SEL_W  = 2,
  parameter int TIME_W = 64,
  parameter int DEPTH  = 4,
  localparam int STAT_W = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_edge,
  input  logic [SEL_W-1:0]  cfg_src,
  input  logic [SEL_W-1:0]  cfg_gsel,
  input  logic              cfg_gen,
  input  logic              cfg_gpol,
  input  logic [N_IN-1:0]   level,
  input  logic [N_IN-1:0]   rise,
  input  logic [N_IN-1:0]   fall,
  input  logic [TIME_W-1:0] time_now,
  input  logic [STAT_W-1:0] status_now,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic              trig,
  output logic              nonempty,
  output logic              full,
  output logic              ovf,
  output logic [TIME_W-1:0] head_time,
  output logic [STAT_W-1:0] head_stat
);

  logic                     empty;
  logic                     push;
  logic [TIME_W+STAT_W-1:0] head;

  assign trig = cfg_en
              & gate_open(cfg_gen, cfg_gpol, level[cfg_gsel])
              & edge_hit(cfg_edge, rise[cfg_src], fall[cfg_src]);
  assign push = trig & ~full;

  ts_cap_fifo #(.W(TIME_W + STAT_W), .DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   ({time_now, status_now}),
    .pop   (pop),
    .dout  (head),
    .empty (empty),
    .full  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ovf <= 1'b0;
    else if (trig && full) ovf <= 1'b1;
    else if (ovf_clr)      ovf <= 1'b0;
  end

  assign nonempty  = ~empty;
  assign head_time = head[TIME_W+STAT_W-1:STAT_W];
  assign head_stat = head[STAT_W-1:0];

endmodule

// File: rtl/ts_capture_bank.sv
module ts_capture_bank
  import ts_cap_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_IN      = 4,
  parameter int TIME_W      = 64,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int STAT_W = 2 * NUM_IN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TIME_W-1:0]       time_now,
  input  logic [NUM_IN-1:0]       ext_in,
  input  logic [NUM_CH-1:0]       cfg_enable,
  input  logic [2*NUM_CH-1:0]     cfg_edge,
  input  logic [NUM_CH*SEL_W-1:0] cfg_trig_sel,
  input  logic [NUM_CH*SEL_W-1:0] cfg_gate_sel,
  input  logic [NUM_CH-1:0]       cfg_gate_en,
  input  logic [NUM_CH-1:0]       cfg_gate_pol,
  input  logic [NUM_CH-1:0]       irq_en,
  input  logic [NUM_CH-1:0]       ovf_clr,
  input  logic [CH_W-1:0]         rd_ch,
  input  logic                    rd_pop,
  output logic                    rd_valid,
  output logic [TIME_W-1:0]       rd_time,
  output logic [STAT_W-1:0]       rd_status,
  output logic [NUM_CH-1:0]       ovf_flags,
  output logic                    irq,
  output logic [CH_W-1:0]         irq_ch
);

  function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) idx = CH_W'(i);
    end
    return idx;
  endfunction

  // Named internal events, observed by the bound checker.
  logic [NUM_IN-1:0] in_level;
  logic [NUM_IN-1:0] in_rise;
  logic [NUM_IN-1:0] in_fall;
  logic [STAT_W-1:0] status_now;
  logic [NUM_CH-1:0] cap_trig;
  logic [NUM_CH-1:0] ch_nonempty;
  logic [NUM_CH-1:0] ch_full;
  logic [NUM_CH-1:0] ch_pop;
  logic [NUM_CH-1:0] irq_pending;
  logic [TIME_W-1:0] head_time [NUM_CH];
  logic [STAT_W-1:0] head_stat [NUM_CH];

  ts_cap_sync #(.N_IN(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_in),
    .level    (in_level),
    .rise     (in_rise),
    .fall     (in_fall)
  );

  assign status_now = {in_rise | in_fall, in_level};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_pop[c] = rd_pop & ch_nonempty[c] & (rd_ch == CH_W'(c));

    ts_cap_channel #(
      .N_IN   (NUM_IN),
      .SEL_W  (SEL_W),
      .TIME_W (TIME_W),
      .DEPTH  (FIFO_DEPTH)
    ) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_enable[c]),
      .cfg_edge   (cfg_edge[2*c +: 2]),
      .cfg_src    (cfg_trig_sel[c*SEL_W +: SEL_W]),
      .cfg_gsel   (cfg_gate_sel[c*SEL_W +: SEL_W]),
      .cfg_gen    (cfg_gate_en[c]),
      .cfg_gpol   (cfg_gate_pol[c]),
      .level      (in_level),
      .rise       (in_rise),
      .fall       (in_fall),
      .time_now   (time_now),
      .status_now (status_now),
      .pop        (ch_pop[c]),
      .ovf_clr    (ovf_clr[c]),
      .trig       (cap_trig[c]),
      .nonempty   (ch_nonempty[c]),
      .full       (ch_full[c]),
      .ovf        (ovf_flags[c]),
      .head_time  (head_time[c]),
      .head_stat  (head_stat[c])
    );
  end

  assign rd_valid  = ch_nonempty[rd_ch];
  assign rd_time   = head_time[rd_ch];
  assign rd_status = head_stat[rd_ch];

  assign irq_pending = ch_nonempty & irq_en;
  assign irq         = |irq_pending;
  assign irq_ch      = lowest_set(irq_pending);

endmodule

// File: rtl/ts_capture_bank_chk.sv
module ts_capture_bank_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int TIME_W = 64,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ovf_flags,
  input logic [NUM_CH-1:0] ovf_clr,
  input logic [NUM_CH-1:0] cap_trig,
  input logic [NUM_CH-1:0] ch_full,
  input logic [NUM_CH-1:0] ch_nonempty,
  input logic [NUM_CH-1:0] irq_en,
  input logic              irq,
  input logic [CH_W-1:0]   irq_ch,
  input logic              rd_valid,
  input logic              rd_pop,
  input logic [CH_W-1:0]   rd_ch,
  input logic [TIME_W-1:0] rd_time,
  input logic [STAT_W-1:0] rd_status
);

  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  // R8: an overflow bit not being cleared stays set
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_flags & ~ovf_clr)) |=>
      ((ovf_flags & $past(ovf_flags & ~ovf_clr)) == $past(ovf_flags & ~ovf_clr)));

  // R8: a trigger meeting a full FIFO raises the overflow bit
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cap_trig & ch_full)) |=>
      ((ovf_flags & $past(cap_trig & ch_full)) == $past(cap_trig & ch_full)));

  // R9: the reported channel is really pending
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ch_nonempty[irq_ch] && irq_en[irq_ch]));

  // R9: no lower-numbered channel is pending
  a_r9_irq_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ch_nonempty & irq_en & ((ONE << irq_ch) - ONE)) == '0));

  // R10: head record held while neither popped nor reselected
  a_r10_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_pop) |=>
      (!$stable(rd_ch) || (rd_valid && $stable(rd_time) && $stable(rd_status))));

endmodule

bind ts_capture_bank ts_capture_bank_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .TIME_W (TIME_W),
  .STAT_W (STAT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ovf_flags   (ovf_flags),
  .ovf_clr     (ovf_clr),
  .cap_trig    (cap_trig),
  .ch_full     (ch_full),
  .ch_nonempty (ch_nonempty),
  .irq_en      (irq_en),
  .irq         (irq),
  .irq_ch      (irq_ch),
  .rd_valid    (rd_valid),
  .rd_pop      (rd_pop),
  .rd_ch       (rd_ch),
  .rd_time     (rd_time),
  .rd_status   (rd_status)
);

// File: tb/ts_capture_bank_tb_top.sv
`timescale 1ns/1ps
module ts_capture_bank_tb_top;

  localparam int NCH = 4;
  localparam int NIN = 4;

  // Vector: [7:6] edge select, [5] gate enable, [4] gate polarity,
  // [3] gate level, [2] source level before, [1] after, [0] capture expected
  localparam logic [7:0] VEC [12] = '{
    8'b01000011, 8'b01000100, 8'b10000101, 8'b10000010,
    8'b11000011, 8'b11000101, 8'b00000010, 8'b01111011,
    8'b01110010, 8'b01100011, 8'b01101010, 8'b10111101
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tnow = 64'h0000_0000_FFFF_FFF0;
  logic [3:0]  ext_in = '0;
  logic [3:0]  cfg_enable = '0;
  logic [7:0]  cfg_edge = '0;
  logic [7:0]  cfg_trig_sel = '0;
  logic [7:0]  cfg_gate_sel = '0;
  logic [3:0]  cfg_gate_en = '0;
  logic [3:0]  cfg_gate_pol = '0;
  logic [3:0]  irq_en = '0;
  logic [3:0]  ovf_clr = '0;
  logic [1:0]  rd_ch = '0;
  logic        rd_pop = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_time;
  logic [7:0]  rd_status;
  logic [3:0]  ovf_flags;
  logic        irq;
  logic [1:0]  irq_ch;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 64'd1;

  ts_capture_bank #(
    .NUM_CH(NCH), .NUM_IN(NIN), .TIME_W(64), .FIFO_DEPTH(2), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .time_now(tnow), .ext_in(ext_in),
    .cfg_enable(cfg_enable), .cfg_edge(cfg_edge), .cfg_trig_sel(cfg_trig_sel),
    .cfg_gate_sel(cfg_gate_sel), .cfg_gate_en(cfg_gate_en), .cfg_gate_pol(cfg_gate_pol),
    .irq_en(irq_en), .ovf_clr(ovf_clr), .rd_ch(rd_ch), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_time(rd_time), .rd_status(rd_status),
    .ovf_flags(ovf_flags), .irq(irq), .irq_ch(irq_ch)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ch(input int c, input logic en, input logic [1:0] e,
                        input logic [1:0] src, input logic [1:0] gs,
                        input logic gen, input logic gpol);
    cfg_enable[c]       = en;
    cfg_edge[2*c +: 2]  = e;
    cfg_trig_sel[2*c +: 2] = src;
    cfg_gate_sel[2*c +: 2] = gs;
    cfg_gate_en[c]      = gen;
    cfg_gate_pol[c]     = gpol;
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic drain(input logic [1:0] ch);
    rd_ch = ch;
    @(negedge clk);
    while (rd_valid) begin
      pop_one();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    logic [63:0] ta;
    logic [63:0] tb;
    irq_en = 4'hF;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 ovf_flags", {60'd0, ovf_flags}, 64'd0);

    // Table walk on channel 0: source input 0, gate input 1 (R2 R3 R4 R6)
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = VEC[i];
      set_ch(0, 1'b0, 2'b00, 2'd0, 2'd1, 1'b0, 1'b0);
      ext_in = {1'b1, 1'b0, v[3], v[2]};
      tick(4);
      drain(2'd0);
      set_ch(0, 1'b1, v[7:6], 2'd0, 2'd1, v[5], v[4]);
      tick(1);
      t0 = tnow;
      ext_in[0] = v[1];
      tick(4);
      chk("R3/R4 capture taken", {63'd0, rd_valid}, {63'd0, v[0]});
      if (v[0] && rd_valid) begin
        chk("R2 timestamp latency", rd_time, t0 + 64'd2);
        chk("R6 status word", {56'd0, rd_status}, {56'd0, 4'b0001, 1'b1, 1'b0, v[3], v[1]});
        pop_one();
      end
    end

    // R7 / R8 / R10: ordering, overflow, head stability on channel 0
    set_ch(0, 1'b0, 2'b00, 2'd0, 2'd1, 1'b0, 1'b0);
    ext_in = 4'b0000;
    tick(4);
    drain(2'd0);
    set_ch(0, 1'b1, 2'b11, 2'd0, 2'd1, 1'b0, 1'b0);
    tick(1);
    ta = tnow;
    ext_in[0] = 1'b1;
    tick(4);
    chk("R10 head before second capture", rd_time, ta + 64'd2);
    tb = tnow;
    ext_in[0] = 1'b0;
    tick(4);
    chk("R10 head unchanged by later capture", rd_time, ta + 64'd2);
    ext_in[0] = 1'b1;
    tick(4);
    chk("R8 overflow set", {63'd0, ovf_flags[0]}, 64'd1);
    chk("R7 first record", rd_time, ta + 64'd2);
    pop_one();
    chk("R7 second record", rd_time, tb + 64'd2);
    pop_one();
    chk("R8 dropped capture not stored", {63'd0, rd_valid}, 64'd0);
    chk("R8 overflow still set", {63'd0, ovf_flags[0]}, 64'd1);
    ovf_clr[0] = 1'b1;
    tick(1);
    ovf_clr[0] = 1'b0;
    chk("R8 overflow cleared", {63'd0, ovf_flags[0]}, 64'd0);
    set_ch(0, 1'b0, 2'b00, 2'd0, 2'd1, 1'b0, 1'b0);

    // R5 / R9 / R11: channels 1,2 enabled on input 2 rising, channel 3 disabled
    set_ch(1, 1'b1, 2'b01, 2'd2, 2'd0, 1'b0, 1'b0);
    set_ch(2, 1'b1, 2'b01, 2'd2, 2'd0, 1'b0, 1'b0);
    set_ch(3, 1'b0, 2'b01, 2'd2, 2'd0, 1'b0, 1'b0);
    tick(2);
    t0 = tnow;
    ext_in[2] = 1'b1;
    tick(4);
    chk("R9 irq pending", {63'd0, irq}, 64'd1);
    chk("R9 lowest channel", {62'd0, irq_ch}, 64'd1);
    irq_en[1] = 1'b0;
    tick(1);
    chk("R9 masked channel skipped", {62'd0, irq_ch}, 64'd2);
    irq_en = 4'h0;
    tick(1);
    chk("R9 irq off when all masked", {63'd0, irq}, 64'd0);
    // R7: pop on empty channel 0 is ignored
    rd_ch = 2'd0;
    pop_one();
    rd_ch = 2'd1;
    tick(1);
    chk("R7 empty pop ignored", {63'd0, rd_valid}, 64'd1);
    chk("R11 channel 1 time", rd_time, t0 + 64'd2);
    pop_one();
    chk("R7 channel 1 emptied", {63'd0, rd_valid}, 64'd0);
    rd_ch = 2'd2;
    tick(1);
    chk("R11 channel 2 time", rd_time, t0 + 64'd2);
    rd_ch = 2'd3;
    tick(1);
    chk("R5 disabled channel empty", {63'd0, rd_valid}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule